// File: doc/BRIEF.md
# Node Address Record Validator

This block inspects the opening bytes of a 32-byte memory page as they stream past, one byte per valid strobe, in rising address order. The page is expected to begin with a short length-prefixed record. The record carries a fixed project identifier, a 48-bit network node address and a closing check word. The block checks the length byte and the two constant fields byte by byte as they arrive. It assembles the node address with the least significant byte first and runs a CRC16 over the record body. When the last check byte arrives, it compares the CRC against the complement of the stored word.

A start-of-page pulse begins a new parse at address 0, and it may land in the middle of a record to abort it. At the end of the record the block raises a one-cycle done pulse. Along with that pulse it presents the assembled address, a record-good flag and four latched error flags. It can also check the unused remainder of the page and raise a separate, non-fatal warning when that area is not blank. All result flags hold their value until the next start-of-page pulse.

Top module: `nar_validator`

## Requirements
- R1: The byte at page address 0 must equal 0Ah; any other value sets `err_len_o`.
- R2: Addresses 1 to 4 form a 32-bit project identifier, least significant byte at address 1, that must equal 00001129h; any mismatching byte sets `err_proj_o`.
- R3: Addresses 5 to 10 form the 48-bit node address, least significant byte at address 5, and `node_addr_o` shows it once the record is complete.
- R4: Bits 47:24 of the node address (addresses 8 to 10) are the company ID and must equal 006035h; otherwise `err_comp_o` is set.
- R5: The CRC uses polynomial x^16+x^15+x^2+1, is processed LSB first from a zero seed, and covers addresses 0 to 10. Address 11 holds the low byte and address 12 the high byte of its bitwise complement. A mismatch sets `err_crc_o`.
- R6: `done_o` is high for exactly one cycle, in the cycle after the byte at address 12 is accepted. `rec_ok_o` rises in that same cycle only if none of R1, R2, R4 or R5 flagged an error.
- R7: Error flags and `rec_ok_o` stay latched until the next start-of-page pulse.
- R8: `sop_i` clears the address, all flags and the CRC, and restarts the parse at address 0. A byte strobed in the same cycle as `sop_i` is taken as address 0.
- R9: When tail checking is enabled, any byte at addresses 13 to 31 that is not FFh sets `warn_tail_o`. This warning has no effect on `rec_ok_o`.
- R10: Cycles without `byte_vld_i` change nothing, and bytes strobed after address 31 are ignored.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sop_i | input | 1 | Start-of-page pulse |
| byte_vld_i | input | 1 | Byte strobe |
| byte_i | input | 8 | Page byte |
| node_addr_o | output | 48 | Assembled node address |
| done_o | output | 1 | Record-complete pulse |
| rec_ok_o | output | 1 | Record passed every check |
| err_len_o | output | 1 | Length byte wrong |
| err_proj_o | output | 1 | Project identifier wrong |
| err_comp_o | output | 1 | Company ID wrong |
| err_crc_o | output | 1 | Check word mismatch |
| warn_tail_o | output | 1 | Non-blank byte after the record |

## Verification
Several properties are checked on every cycle. The done pulse is a single cycle and always follows an accepted byte. The good flag never coexists with an error flag and can rise only with done. Latched error flags survive until a start-of-page pulse, and that pulse clears everything. The address stays stable through idle cycles. The remaining checks need the bench's scenarios: the field and CRC checks against known good and corrupted pages, the little-endian assembly of the address, the tail warning, bytes past the page end, and aborting a record part way through.

// File: rtl/nar_pkg.sv
package nar_pkg;

  // Record layout (byte positions within the page)
  localparam int REC_POS_LEN    = 0;
  localparam int REC_POS_PROJ0  = 1;
  localparam int REC_POS_PROJ3  = 4;
  localparam int REC_POS_ADDR0  = 5;
  localparam int REC_POS_COMP0  = 8;
  localparam int REC_POS_ADDR5  = 10;
  localparam int REC_POS_CRC_LO = 11;
  localparam int REC_POS_CRC_HI = 12;
  localparam int REC_ADDR_BYTES = 6;

  // Reflected form of x^16+x^15+x^2+1
  localparam logic [15:0] CRC_POLY_REFL = 16'hA001;
  localparam logic [15:0] CRC_SEED      = 16'h0000;

  function automatic logic [15:0] crc16_byte(input logic [15:0] c,
                                             input logic [7:0]  d,
                                             input logic [15:0] poly);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/nar_rst_sync.sv
module nar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/nar_byte_shift.sv
module nar_byte_shift #(
  parameter int BYTES = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [7:0]         din,
  output logic [8*BYTES-1:0] q
);
  localparam int W = 8 * BYTES;

  logic [W-1:0] q_d, q_q;
  logic [W-1:0] shifted;

  // New bytes enter at the top so the first byte ends up least significant
  generate
    if (BYTES == 1) begin : g_single
      assign shifted = din;
    end else begin : g_multi
      assign shifted = {din, q_q[W-1:8]};
    end
  endgenerate

  always_comb begin
    q_d = q_q;
    if (clr)     q_d = '0;
    else if (en) q_d = shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/nar_crc16.sv
module nar_crc16
  import nar_pkg::*;
#(
  parameter logic [15:0] POLY = CRC_POLY_REFL,
  parameter logic [15:0] SEED = CRC_SEED
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_o
);
  logic [15:0] crc_d, crc_q;
  logic [15:0] base;

  always_comb begin
    base  = clr ? SEED : crc_q;
    crc_d = en ? crc16_byte(base, din, POLY) : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= SEED;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/nar_validator.sv
module nar_validator
  import nar_pkg::*;
#(
  parameter int          PAGE_BYTES    = 32,
  parameter bit          CHECK_TAIL    = 1'b1,
  parameter logic [7:0]  LEN_VALUE     = 8'h0A,
  parameter logic [31:0] PROJ_VALUE    = 32'h0000_1129,
  parameter logic [23:0] COMPANY_VALUE = 24'h00_6035,
  parameter logic [7:0]  BLANK_VALUE   = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sop_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  output logic [47:0] node_addr_o,
  output logic        done_o,
  output logic        rec_ok_o,
  output logic        err_len_o,
  output logic        err_proj_o,
  output logic        err_comp_o,
  output logic        err_crc_o,
  output logic        warn_tail_o
);
  localparam int IDX_W = $clog2(PAGE_BYTES + 1);
  localparam logic [IDX_W-1:0] P_LEN    = IDX_W'(REC_POS_LEN);
  localparam logic [IDX_W-1:0] P_PROJ0  = IDX_W'(REC_POS_PROJ0);
  localparam logic [IDX_W-1:0] P_PROJ3  = IDX_W'(REC_POS_PROJ3);
  localparam logic [IDX_W-1:0] P_ADDR0  = IDX_W'(REC_POS_ADDR0);
  localparam logic [IDX_W-1:0] P_COMP0  = IDX_W'(REC_POS_COMP0);
  localparam logic [IDX_W-1:0] P_ADDR5  = IDX_W'(REC_POS_ADDR5);
  localparam logic [IDX_W-1:0] P_CRC_LO = IDX_W'(REC_POS_CRC_LO);
  localparam logic [IDX_W-1:0] P_CRC_HI = IDX_W'(REC_POS_CRC_HI);
  localparam logic [IDX_W-1:0] P_END    = IDX_W'(PAGE_BYTES);
  localparam logic [31:0]      COMP32   = {8'h00, COMPANY_VALUE};

  logic rst_s_n;
  nar_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n));

  // Byte position tracking
  logic [IDX_W-1:0] idx_q, idx_d, cur_idx;
  logic             take;

  assign cur_idx = sop_i ? '0 : idx_q;
  assign take    = byte_vld_i && (cur_idx < P_END);
  assign idx_d   = take ? cur_idx + 1'b1 : cur_idx;

  // Field windows
  logic in_proj, in_addr, in_comp, in_body, is_last;
  assign in_proj = (cur_idx >= P_PROJ0) && (cur_idx <= P_PROJ3);
  assign in_addr = (cur_idx >= P_ADDR0) && (cur_idx <= P_ADDR5);
  assign in_comp = (cur_idx >= P_COMP0) && (cur_idx <= P_ADDR5);
  assign in_body = (cur_idx <= P_ADDR5);
  assign is_last = take && (cur_idx == P_CRC_HI);

  // Expected constant bytes: project bytes sit at 1..4, company at 8..10
  logic [1:0] proj_sel;
  logic [7:0] proj_exp, comp_exp;
  assign proj_sel = cur_idx[1:0] - 2'd1;
  assign proj_exp = PROJ_VALUE[{proj_sel, 3'b000} +: 8];
  assign comp_exp = COMP32[{cur_idx[1:0], 3'b000} +: 8];

  // Datapath units
  logic [47:0] addr_q;
  logic [7:0]  crc_lo_q;
  logic [15:0] crc_val;

  nar_byte_shift #(.BYTES(REC_ADDR_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_s_n), .clr(sop_i), .en(take && in_addr),
    .din(byte_i), .q(addr_q));

  nar_byte_shift #(.BYTES(1)) u_crc_lo (
    .clk(clk), .rst_n(rst_s_n), .clr(sop_i),
    .en(take && (cur_idx == P_CRC_LO)), .din(byte_i), .q(crc_lo_q));

  nar_crc16 u_crc (
    .clk(clk), .rst_n(rst_s_n), .clr(sop_i), .en(take && in_body),
    .din(byte_i), .crc_o(crc_val));

  // Result flags
  logic err_len_q, err_proj_q, err_comp_q, err_crc_q, ok_q, done_q, warn_q;
  logic err_len_d, err_proj_d, err_comp_d, err_crc_d, ok_d, done_d, warn_d;
  logic crc_bad, keep;

  assign crc_bad = (~{byte_i, crc_lo_q}) != crc_val;
  assign keep    = !sop_i;

  always_comb begin
    err_len_d  = (err_len_q  && keep) || (take && (cur_idx == P_LEN) && (byte_i != LEN_VALUE));
    err_proj_d = (err_proj_q && keep) || (take && in_proj && (byte_i != proj_exp));
    err_comp_d = (err_comp_q && keep) || (take && in_comp && (byte_i != comp_exp));
    err_crc_d  = (err_crc_q  && keep) || (is_last && crc_bad);
    done_d     = is_last;
    if (is_last) ok_d = !(err_len_q || err_proj_q || err_comp_q || crc_bad);
    else         ok_d = ok_q && keep;
  end

  generate
    if (CHECK_TAIL) begin : g_tail
      assign warn_d = (warn_q && keep) ||
                      (take && (cur_idx > P_CRC_HI) && (byte_i != BLANK_VALUE));
    end else begin : g_no_tail
      assign warn_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      idx_q      <= '0;
      err_len_q  <= 1'b0;
      err_proj_q <= 1'b0;
      err_comp_q <= 1'b0;
      err_crc_q  <= 1'b0;
      ok_q       <= 1'b0;
      done_q     <= 1'b0;
      warn_q     <= 1'b0;
    end else begin
      idx_q      <= idx_d;
      err_len_q  <= err_len_d;
      err_proj_q <= err_proj_d;
      err_comp_q <= err_comp_d;
      err_crc_q  <= err_crc_d;
      ok_q       <= ok_d;
      done_q     <= done_d;
      warn_q     <= warn_d;
    end
  end

  assign node_addr_o = addr_q;
  assign done_o      = done_q;
  assign rec_ok_o    = ok_q;
  assign err_len_o   = err_len_q;
  assign err_proj_o  = err_proj_q;
  assign err_comp_o  = err_comp_q;
  assign err_crc_o   = err_crc_q;
  assign warn_tail_o = warn_q;
endmodule

// File: rtl/nar_validator_chk.sv
module nar_validator_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sop_i,
  input logic        byte_vld_i,
  input logic [47:0] node_addr_o,
  input logic        done_o,
  input logic        rec_ok_o,
  input logic        err_len_o,
  input logic        err_proj_o,
  input logic        err_comp_o,
  input logic        err_crc_o,
  input logic        warn_tail_o
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(byte_vld_i));

  p_ok_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ok_o |-> !(err_len_o || err_proj_o || err_comp_o || err_crc_o));

  p_ok_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_ok_o) |-> done_o);

  p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_len_o && !sop_i |=> err_len_o);

  p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc_o && !sop_i |=> err_crc_o);

  p_sop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sop_i && !byte_vld_i |=> !(rec_ok_o || done_o || err_len_o || err_proj_o ||
                               err_comp_o || err_crc_o || warn_tail_o) &&
                              (node_addr_o == 48'h0));

  p_addr_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld_i && !sop_i |=> $stable(node_addr_o));
endmodule

bind nar_validator nar_validator_chk u_chk (.*);

// File: tb/nar_validator_bench.sv
`timescale 1ns/1ps
module nar_validator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop_i = 1'b0;
  logic        byte_vld_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic [47:0] node_addr_o;
  logic        done_o, rec_ok_o, err_len_o, err_proj_o, err_comp_o, err_crc_o, warn_tail_o;

  always #2 clk = ~clk;

  nar_validator u_nar_validator (
    .clk(clk), .rst_n(rst_n), .sop_i(sop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .node_addr_o(node_addr_o), .done_o(done_o), .rec_ok_o(rec_ok_o),
    .err_len_o(err_len_o), .err_proj_o(err_proj_o), .err_comp_o(err_comp_o),
    .err_crc_o(err_crc_o), .warn_tail_o(warn_tail_o));

  typedef struct packed {
    logic [7:0]  len;
    logic [31:0] proj;
    logic [23:0] comp;
    logic [23:0] ext;
    logic [15:0] flip;
    logic [7:0]  tail;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'h0A, 32'h0000_1129, 24'h006035, 24'h67ABCD, 16'h0000, 8'hFF},
    '{8'h0B, 32'h0000_1129, 24'h006035, 24'h00F00D, 16'h0000, 8'hFF},
    '{8'h0A, 32'h0000_1128, 24'h006035, 24'hA5A5A5, 16'h0000, 8'hFF},
    '{8'h0A, 32'h0000_1129, 24'h006036, 24'h123456, 16'h0000, 8'hFF},
    '{8'h0A, 32'h0000_1129, 24'h006035, 24'hFFFFFF, 16'h0001, 8'hFF},
    '{8'h0A, 32'h0000_1129, 24'h006035, 24'h000000, 16'h0000, 8'h00},
    '{8'h0A, 32'h1129_0000, 24'h000000, 24'h89ABCD, 16'h8000, 8'h7E}
  };

  int checks = 0;
  int errors = 0;
  logic [7:0] pg [32];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pg[i][b];
        c  = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  task automatic build(input vec_t v);
    logic [47:0] a;
    logic [15:0] s;
    a = {v.comp, v.ext};
    pg[0] = v.len;
    for (int i = 0; i < 4; i++) pg[1+i] = v.proj[8*i +: 8];
    for (int i = 0; i < 6; i++) pg[5+i] = a[8*i +: 8];
    s = ~ref_crc(11) ^ v.flip;
    pg[11] = s[7:0];
    pg[12] = s[15:8];
    for (int i = 13; i < 32; i++) pg[i] = 8'hFF;
    pg[20] = v.tail;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
    @(negedge clk); byte_vld_i = 1'b0;
  endtask

  task automatic pulse_sop();
    @(negedge clk); sop_i = 1'b1;
    @(negedge clk); sop_i = 1'b0;
  endtask

  task automatic check_result(input vec_t v, input string tag);
    logic el, ep, ec, ecr;
    el  = v.len  != 8'h0A;
    ep  = v.proj != 32'h0000_1129;
    ec  = v.comp != 24'h006035;
    ecr = v.flip != 16'h0;
    chk({"R3 addr ", tag}, node_addr_o, {v.comp, v.ext});
    chk({"R1 len ", tag},  err_len_o,  el);
    chk({"R2 proj ", tag}, err_proj_o, ep);
    chk({"R4 comp ", tag}, err_comp_o, ec);
    chk({"R5 crc ", tag},  err_crc_o,  ecr);
    chk({"R6 ok ", tag},   rec_ok_o,   !(el || ep || ec || ecr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 reset addr", node_addr_o, 48'h0);
    chk("R11 reset flags", {done_o, rec_ok_o, err_len_o, err_proj_o, err_comp_o, err_crc_o, warn_tail_o}, 7'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("vec%0d", k);
      build(VECS[k]);
      pulse_sop();
      for (int i = 0; i < 12; i++) put(pg[i]);
      chk({"R6 no early done ", tag}, done_o, 1'b0);
      put(pg[12]);
      chk({"R6 done ", tag}, done_o, 1'b1);
      check_result(VECS[k], tag);
      for (int i = 13; i < 32; i++) put(pg[i]);
      chk({"R6 done single ", tag}, done_o, 1'b0);
      chk({"R9 warn ", tag}, warn_tail_o, VECS[k].tail != 8'hFF);
      put(8'h55); put(8'h00);
      chk({"R10 past page warn ", tag}, warn_tail_o, VECS[k].tail != 8'hFF);
      repeat (3) @(negedge clk);
      check_result(VECS[k], {tag, " R7 latched R10"});
    end

    // R7 then R8: errors persist while idle, sop clears
    build(VECS[6]);
    pulse_sop();
    for (int i = 0; i < 13; i++) put(pg[i]);
    repeat (10) @(negedge clk);
    chk("R7 held comp", err_comp_o, 1'b1);
    chk("R7 held crc", err_crc_o, 1'b1);
    pulse_sop();
    chk("R8 sop clears flags", {rec_ok_o, err_len_o, err_proj_o, err_comp_o, err_crc_o, warn_tail_o}, 6'h0);
    chk("R8 sop clears addr", node_addr_o, 48'h0);

    // R8: abort part way through a bad record, then a good one
    build(VECS[1]);
    for (int i = 0; i < 7; i++) put(pg[i]);
    build(VECS[0]);
    pulse_sop();
    for (int i = 0; i < 13; i++) put(pg[i]);
    chk("R8 abort then good ok", rec_ok_o, 1'b1);
    chk("R8 abort then good len", err_len_o, 1'b0);
    chk("R8 abort then good addr", node_addr_o, 48'h0060_3567_ABCD);

    // R8: sop together with the first byte
    build(VECS[2]);
    pulse_sop();
    for (int i = 0; i < 13; i++) put(pg[i]);
    build(VECS[5]);
    @(negedge clk); sop_i = 1'b1; byte_vld_i = 1'b1; byte_i = pg[0];
    @(negedge clk); sop_i = 1'b0; byte_vld_i = 1'b0;
    for (int i = 1; i < 13; i++) put(pg[i]);
    chk("R8 sop with byte done", done_o, 1'b1);
    chk("R8 sop with byte ok", rec_ok_o, 1'b1);
    chk("R8 sop with byte proj", err_proj_o, 1'b0);
    chk("R8 sop with byte addr", node_addr_o, 48'h0060_3500_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule